// File: doc/BRIEF.md
# Condition Flag Compare Unit

This block evaluates the compare and test instructions of a 32-bit integer core. It takes two register operands, Rn and Rm, an 8-bit immediate and a 4-bit operation code, and computes the new condition bit T. The two divide-setup operations also produce the divide-step bits Q and M. The decode logic issues one operation per cycle by raising `opValid`. One clock later the registered results appear together with a result strobe. The status register outside the block takes them in through per-bit write enables.

The operation families are equality, unsigned and signed ordering, sign tests against zero, a byte-lane any-match, a bitwise-AND zero test, signed divide setup and unsigned divide setup. For the equality and test forms the immediate can stand in for Rm. An unknown operation code leaves T at the value supplied on `tIn` and raises an error pulse for one cycle.

Top module: `cmpFlagUnit`

## Requirements
- R1: Results appear on the outputs in the cycle after `opValid` is sampled high, and `resValid` is high for exactly that cycle. When no operation was issued, `qWe`, `mWe` and `invalidOp` are low and `tOut` holds its last value.
- R2: Opcode 0 (EQ) sets T when Rn equals the second operand. With `useImm`=1 the second operand is `immVal` sign-extended from bit 7.
- R3: Opcode 1 (HS) sets T when Rn >= Rm unsigned. Opcode 3 (HI) sets T when Rn > Rm unsigned.
- R4: Opcode 2 (GE) sets T when Rn >= Rm as two's-complement values. Opcode 4 (GT) sets T when Rn > Rm signed.
- R5: Opcode 5 (PZ) sets T when signed Rn >= 0. Opcode 6 (PL) sets T when signed Rn > 0. Rm is not used by either.
- R6: Opcode 7 (STR) sets T when at least one of the four byte lanes of Rn equals the same lane of Rm.
- R7: Opcode 8 (TST) sets T when the bitwise AND of Rn and the second operand is zero. With `useImm`=1 the second operand is the sign-extended immediate.
- R8: Opcode 9 (DIV0S) sets Q to bit 31 of Rn, M to bit 31 of Rm, and T to Q XOR M.
- R9: Opcode 10 (DIV0U) clears Q, M and T.
- R10: `qWe` and `mWe` are high only in result cycles of opcodes 9 and 10. In every other cycle they are low, so the status register keeps its Q and M.
- R11: For opcodes 11 to 15, `tOut` equals the `tIn` that was sampled with the operation, `invalidOp` is high for that one result cycle, and `qWe`/`mWe` stay low.
- R12: For opcodes other than 0 and 8, `useImm` has no effect: Rm is used.
- R13: While `rstN` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | An operation is issued this cycle |
| opCode | input | 4 | Operation code (see requirements) |
| useImm | input | 1 | Use the immediate in place of Rm (EQ, TST only) |
| rnVal | input | 32 | Operand Rn |
| rmVal | input | 32 | Operand Rm |
| immVal | input | 8 | Immediate, sign-extended internally |
| tIn | input | 1 | Current T, passed through on unknown opcodes |
| tOut | output | 1 | New T |
| qOut | output | 1 | New Q |
| mOut | output | 1 | New M |
| qWe | output | 1 | Write enable for Q |
| mWe | output | 1 | Write enable for M |
| invalidOp | output | 1 | Unknown opcode pulse |
| resValid | output | 1 | Result strobe |

## Verification
Each of this block's results, including T, Q, M, their enables and the error pulse, is due exactly one clock after the issuing cycle, and `resValid` marks that cycle. The driver applies each operation on a falling edge and queues the expected outcome. The monitor reads the outputs on the next falling edge, half a period after the capturing rising edge, and pops one queued item for every cycle where `resValid` is high. In cycles where `resValid` is low, the monitor checks that the enables and the error pulse are low and that T is unchanged.

// File: rtl/cmpPkg.sv
package cmpPkg;
  typedef enum logic [3:0] {
    OP_EQ    = 4'd0,
    OP_HS    = 4'd1,
    OP_GE    = 4'd2,
    OP_HI    = 4'd3,
    OP_GT    = 4'd4,
    OP_PZ    = 4'd5,
    OP_PL    = 4'd6,
    OP_STR   = 4'd7,
    OP_TST   = 4'd8,
    OP_DIVS  = 4'd9,
    OP_DIVU  = 4'd10
  } cmpOp_e;

  localparam int SEL_N = 9;
  localparam int SEL_EQ = 0, SEL_HS = 1, SEL_GE = 2, SEL_HI = 3, SEL_GT = 4;
  localparam int SEL_PZ = 5, SEL_PL = 6, SEL_STR = 7, SEL_TST = 8;

  typedef struct packed {
    logic             immSel;
    logic [SEL_N-1:0] pick;
    logic             divSigned;
    logic             divClear;
    logic             known;
  } cmpStrobe_t;
endpackage

// File: rtl/cmpCtrl.sv
module cmpCtrl
  import cmpPkg::*;
(
  input  logic [3:0]  opCode,
  input  logic        useImm,
  output cmpStrobe_t  strobe
);
  always_comb begin
    strobe = '0;
    strobe.known = 1'b1;
    case (opCode)
      OP_EQ:   begin strobe.pick[SEL_EQ]  = 1'b1; strobe.immSel = useImm; end
      OP_HS:   strobe.pick[SEL_HS]  = 1'b1;
      OP_GE:   strobe.pick[SEL_GE]  = 1'b1;
      OP_HI:   strobe.pick[SEL_HI]  = 1'b1;
      OP_GT:   strobe.pick[SEL_GT]  = 1'b1;
      OP_PZ:   strobe.pick[SEL_PZ]  = 1'b1;
      OP_PL:   strobe.pick[SEL_PL]  = 1'b1;
      OP_STR:  strobe.pick[SEL_STR] = 1'b1;
      OP_TST:  begin strobe.pick[SEL_TST] = 1'b1; strobe.immSel = useImm; end
      OP_DIVS: strobe.divSigned = 1'b1;
      OP_DIVU: strobe.divClear  = 1'b1;
      default: strobe.known = 1'b0;
    endcase
  end
endmodule

// File: rtl/cmpDatapath.sv
module cmpDatapath
  import cmpPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int LANE_W = 8
) (
  input  cmpStrobe_t         strobe,
  input  logic [DATA_W-1:0]  rnVal,
  input  logic [DATA_W-1:0]  rmVal,
  input  logic [IMM_W-1:0]   immVal,
  input  logic               tIn,
  output logic               tNext,
  output logic               qNext,
  output logic               mNext
);
  localparam int LANES = DATA_W / LANE_W;

  logic [DATA_W-1:0] opB;
  logic [LANES-1:0]  laneHit;
  logic [SEL_N-1:0]  flags;

  assign opB = strobe.immSel ? {{(DATA_W-IMM_W){immVal[IMM_W-1]}}, immVal} : rmVal;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneHit[g] = rnVal[g*LANE_W +: LANE_W] == rmVal[g*LANE_W +: LANE_W];
  end

  always_comb begin
    flags          = '0;
    flags[SEL_EQ]  = rnVal == opB;
    flags[SEL_HS]  = rnVal >= opB;
    flags[SEL_HI]  = rnVal > opB;
    flags[SEL_GE]  = $signed(rnVal) >= $signed(opB);
    flags[SEL_GT]  = $signed(rnVal) > $signed(opB);
    flags[SEL_PZ]  = !rnVal[DATA_W-1];
    flags[SEL_PL]  = !rnVal[DATA_W-1] && (rnVal != '0);
    flags[SEL_STR] = |laneHit;
    flags[SEL_TST] = (rnVal & opB) == '0;
  end

  always_comb begin
    qNext = strobe.divSigned & rnVal[DATA_W-1];
    mNext = strobe.divSigned & rmVal[DATA_W-1];
    if (strobe.divSigned)     tNext = rnVal[DATA_W-1] ^ rmVal[DATA_W-1];
    else if (strobe.divClear) tNext = 1'b0;
    else if (strobe.known)    tNext = |(flags & strobe.pick);
    else                      tNext = tIn;
  end
endmodule

// File: rtl/cmpFlagUnit.sv
module cmpFlagUnit
  import cmpPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [3:0]        opCode,
  input  logic              useImm,
  input  logic [DATA_W-1:0] rnVal,
  input  logic [DATA_W-1:0] rmVal,
  input  logic [IMM_W-1:0]  immVal,
  input  logic              tIn,
  output logic              tOut,
  output logic              qOut,
  output logic              mOut,
  output logic              qWe,
  output logic              mWe,
  output logic              invalidOp,
  output logic              resValid
);
  cmpStrobe_t strobe;
  logic tNext, qNext, mNext;

  cmpCtrl i_ctrl (.opCode(opCode), .useImm(useImm), .strobe(strobe));

  cmpDatapath #(.DATA_W(DATA_W), .IMM_W(IMM_W), .LANE_W(LANE_W)) i_dp (
    .strobe(strobe), .rnVal(rnVal), .rmVal(rmVal), .immVal(immVal),
    .tIn(tIn), .tNext(tNext), .qNext(qNext), .mNext(mNext)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tOut <= 1'b0; qOut <= 1'b0; mOut <= 1'b0;
      qWe <= 1'b0; mWe <= 1'b0; invalidOp <= 1'b0; resValid <= 1'b0;
    end else begin
      resValid <= opValid;
      if (opValid) begin
        tOut      <= tNext;
        qOut      <= qNext;
        mOut      <= mNext;
        qWe       <= strobe.divSigned | strobe.divClear;
        mWe       <= strobe.divSigned | strobe.divClear;
        invalidOp <= !strobe.known;
      end else begin
        qWe       <= 1'b0;
        mWe       <= 1'b0;
        invalidOp <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cmpFlagUnitChk.sv
module cmpFlagUnitChk (
  input logic       clk,
  input logic       rstN,
  input logic       opValid,
  input logic [3:0] opCode,
  input logic       tIn,
  input logic       tOut,
  input logic       qOut,
  input logic       mOut,
  input logic       qWe,
  input logic       mWe,
  input logic       invalidOp,
  input logic       resValid
);
  assert_res_strobe_R1: assert property (@(posedge clk) disable iff (!rstN)
    resValid == $past(opValid));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> (!qWe && !mWe && !invalidOp));

  assert_div_t_R8: assert property (@(posedge clk) disable iff (!rstN)
    qWe |-> (tOut == (qOut ^ mOut)));

  assert_divu_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 4'd10) |=> (!qOut && !mOut && !tOut && qWe));

  assert_we_pair_R10: assert property (@(posedge clk) disable iff (!rstN)
    qWe == mWe);

  assert_invalid_keep_R11: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode >= 4'd11) |=> (invalidOp && !qWe && tOut == $past(tIn)));
endmodule

bind cmpFlagUnit cmpFlagUnitChk i_chk (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .tIn(tIn),
  .tOut(tOut), .qOut(qOut), .mOut(mOut), .qWe(qWe), .mWe(mWe),
  .invalidOp(invalidOp), .resValid(resValid)
);

// File: tb/test_cmpFlagUnit.sv
module test_cmpFlagUnit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0;
  logic [3:0] opCode = '0;
  logic useImm = 1'b0;
  logic [31:0] rnVal = '0, rmVal = '0;
  logic [7:0] immVal = '0;
  logic tIn = 1'b0;
  logic tOut, qOut, mOut, qWe, mWe, invalidOp, resValid;

  int total = 0;
  int bad = 0;
  logic lastT = 1'b0;

  typedef struct {
    logic t, q, m, we, inv;
    string req;
  } expItem_t;
  expItem_t sb[$];

  always #10 clk = ~clk;

  cmpFlagUnit i_cmpFlagUnit (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .useImm(useImm),
    .rnVal(rnVal), .rmVal(rmVal), .immVal(immVal), .tIn(tIn), .tOut(tOut),
    .qOut(qOut), .mOut(mOut), .qWe(qWe), .mWe(mWe), .invalidOp(invalidOp),
    .resValid(resValid)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic expItem_t model(input logic [3:0] op, input logic ui, input logic [31:0] a,
                                     input logic [31:0] b, input logic [7:0] im, input logic ti,
                                     input string req);
    expItem_t e;
    logic [31:0] s;
    s = (ui && (op == 4'd0 || op == 4'd8)) ? {{24{im[7]}}, im} : b;
    e.req = req; e.q = 1'b0; e.m = 1'b0; e.we = 1'b0; e.inv = 1'b0;
    case (op)
      4'd0: e.t = (a == s);
      4'd1: e.t = (a >= s);
      4'd2: e.t = ($signed(a) >= $signed(s));
      4'd3: e.t = (a > s);
      4'd4: e.t = ($signed(a) > $signed(s));
      4'd5: e.t = ($signed(a) >= 0);
      4'd6: e.t = ($signed(a) > 0);
      4'd7: e.t = (a[7:0] == s[7:0]) || (a[15:8] == s[15:8]) || (a[23:16] == s[23:16]) || (a[31:24] == s[31:24]);
      4'd8: e.t = ((a & s) == 0);
      4'd9: begin e.q = a[31]; e.m = s[31]; e.t = a[31] ^ s[31]; e.we = 1'b1; end
      4'd10: begin e.t = 1'b0; e.we = 1'b1; end
      default: begin e.t = ti; e.inv = 1'b1; end
    endcase
    return e;
  endfunction

  task automatic issue(input logic [3:0] op, input logic ui, input logic [31:0] a,
                       input logic [31:0] b, input logic [7:0] im, input logic ti, input string req);
    @(negedge clk);
    opValid = 1'b1; opCode = op; useImm = ui; rnVal = a; rmVal = b; immVal = im; tIn = ti;
    sb.push_back(model(op, ui, a, b, im, ti, req));
  endtask

  task automatic idle();
    @(negedge clk);
    opValid = 1'b0; opCode = 4'd15; tIn = ~tIn;
  endtask

  // Monitor: results are due one cycle after issue; sample on falling edges.
  initial begin
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (resValid) begin
          if (sb.size() == 0) chk("R1", "unexpected resValid", 1, 0);
          else begin
            expItem_t e;
            e = sb.pop_front();
            chk(e.req, "tOut", tOut, e.t);
            chk(e.req, "qOut", qOut, e.q);
            chk(e.req, "mOut", mOut, e.m);
            chk("R10", "qWe", qWe, e.we);
            chk("R10", "mWe", mWe, e.we);
            chk("R11", "invalidOp", invalidOp, e.inv);
            lastT = tOut;
          end
        end else begin
          chk("R1", "idle strobes", {29'd0, qWe, mWe, invalidOp}, 0);
          chk("R1", "tOut held", tOut, lastT);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    opValid = 1'b1; opCode = 4'd15; tIn = 1'b1;
    repeat (3) @(negedge clk);
    chk("R13", "reset outputs", {25'd0, tOut, qOut, mOut, qWe, mWe, invalidOp, resValid}, 0);
    opValid = 1'b0; tIn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    // R2 equality
    issue(4'd0, 0, 32'h1234_5678, 32'h1234_5678, 8'h00, 0, "R2");
    issue(4'd0, 0, 32'h1234_5678, 32'h1234_5679, 8'h00, 1, "R2");
    issue(4'd0, 1, 32'hFFFF_FF80, 32'h0, 8'h80, 0, "R2");
    issue(4'd0, 1, 32'h0000_0080, 32'h0000_0080, 8'h80, 0, "R2");
    // R3 unsigned
    issue(4'd1, 0, 32'h8000_0000, 32'h7FFF_FFFF, 0, 0, "R3");
    issue(4'd1, 0, 32'h5, 32'h5, 0, 0, "R3");
    issue(4'd3, 0, 32'h5, 32'h5, 0, 0, "R3");
    issue(4'd3, 0, 32'h4, 32'h5, 0, 1, "R3");
    // R4 signed
    issue(4'd2, 0, 32'h8000_0000, 32'h7FFF_FFFF, 0, 0, "R4");
    issue(4'd2, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, "R4");
    issue(4'd4, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, "R4");
    issue(4'd4, 0, 32'h1, 32'hFFFF_FFFF, 0, 0, "R4");
    // R5 sign tests
    issue(4'd5, 0, 32'h0, 32'hFFFF_FFFF, 0, 0, "R5");
    issue(4'd6, 0, 32'h0, 32'h0, 0, 1, "R5");
    issue(4'd6, 0, 32'h7FFF_FFFF, 32'h0, 0, 0, "R5");
    issue(4'd5, 0, 32'h8000_0000, 32'h0, 0, 0, "R5");
    // R6 byte lanes
    issue(4'd7, 0, 32'hAA11_2233, 32'hAA44_5566, 0, 0, "R6");
    issue(4'd7, 0, 32'h1122_3344, 32'h5566_7744, 0, 0, "R6");
    issue(4'd7, 0, 32'h1122_3344, 32'h2211_4433, 0, 1, "R6");
    // R7 test
    issue(4'd8, 0, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 0, 0, "R7");
    issue(4'd8, 0, 32'hF0F0_F0F0, 32'h0000_0010, 0, 1, "R7");
    issue(4'd8, 1, 32'h8000_0000, 32'h0, 8'h80, 0, "R7");
    issue(4'd8, 1, 32'h8000_0000, 32'hFFFF_FFFF, 8'h7F, 1, "R7");
    idle();
    // R8/R9 divide setup
    issue(4'd9, 0, 32'h8000_0000, 32'h0000_0001, 0, 0, "R8");
    issue(4'd9, 0, 32'h8000_0000, 32'h8000_0000, 0, 1, "R8");
    issue(4'd9, 0, 32'h1, 32'hC000_0000, 0, 0, "R8");
    issue(4'd10, 0, 32'hFFFF_FFFF, 32'h8000_0000, 0, 1, "R9");
    idle();
    // R11 unknown opcodes
    issue(4'd11, 0, 0, 0, 0, 1, "R11");
    idle();
    issue(4'd15, 1, 32'h1, 32'h1, 8'h1, 0, "R11");
    issue(4'd13, 0, 0, 0, 0, 1, "R11");
    idle();
    idle();
    // R12 useImm ignored on other ops
    issue(4'd1, 1, 32'h10, 32'h20, 8'h01, 0, "R12");
    issue(4'd7, 1, 32'h0000_0001, 32'hFF00_0001, 8'h55, 0, "R12");
    issue(4'd9, 1, 32'h0, 32'h8000_0000, 8'h00, 0, "R12");
    idle();
    idle();
    idle();
    chk("R1", "scoreboard drained", sb.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule